// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register File

This block is the register window that one core sees for its inter-processor interrupt logic. It holds a 32-bit pending word, a 32-bit enable word, a write-only clear port, a set port that is always refused, and a 32-byte mailbox. A local register bus reaches all of these with accesses of 1, 2, 4 or 8 bytes. A remote dispatcher, which belongs to another part of the chip, can do two things. It can raise one pending bit, and it can write one aligned 32-bit word into the mailbox or into the enable word. The block drives a level interrupt line to its core. The line is high exactly while the pending word holds any bit.

The interrupt line comes from a two-state machine. `IRQ_IDLE` means the pending word is zero and the line is low. `IRQ_RAISED` means the pending word is non-zero and the line is high. The transition *raise* (`IRQ_IDLE` to `IRQ_RAISED`) happens when a remote set lands on an all-zero pending word. The transition *drop* (`IRQ_RAISED` to `IRQ_IDLE`) happens when a clear leaves the pending word at zero. Every other event keeps the current state.

Bus requests last one cycle. The response (valid, read data, error) is registered and appears in the cycle after the request. Read data reflects the state before that request's clock edge.

Top module: `ipi_core_regfile`

## Requirements
- R1: The register offset is the low 9 bits of the bus address. Higher address bits are ignored. The offsets are: pending 0x000, enable 0x004, set 0x008, clear 0x00c, mailbox 0x020 to 0x03f.
- R2: Every cycle with a bus request is followed by exactly one cycle with the response valid, carrying read data and the error bit. A cycle without a request is followed by the response valid low. After reset the response valid, interrupt line and misalignment flag are low.
- R3: The pending word is read-only. A local write to pending or to set returns an error and leaves the pending word unchanged.
- R4: Reads of set and clear succeed and return zero.
- R5: A local write to clear removes every pending bit that is 1 in write data bits 31:0. The interrupt line stays high while any pending bit remains and falls when the pending word reaches zero.
- R6: A remote set with vector v (5 bits) ORs bit v into the pending word. The interrupt line rises only when the pending word was zero before the OR.
- R7: A mailbox access at offset o with size code s covers bytes (o-0x20) to (o-0x20+2^s-1) of the mailbox. The size code values are 0=1, 1=2, 2=4 and 3=8 bytes. Byte k of the access is data bits 8k+7:8k, and read data is zero above the access size.
- R8: A mailbox access with offset plus length above 0x40 returns an error, and its write changes no byte.
- R9: An access to an offset outside the map returns an error. A write to such an offset changes nothing.
- R10: A local write of any size to enable stores write data bits 31:0. A read of enable returns it, zeroed above the access size.
- R11: Any access whose offset is not a multiple of its length sets a misalignment flag. The flag stays set until reset, and the access is otherwise handled normally.
- R12: A remote word write with offset bits 8:2 selecting a mailbox word (0x020 to 0x03c) replaces those 4 bytes. One selecting 0x004 replaces enable. Any other remote offset is ignored.
- R13: When remote and local writes touch the same bytes in one cycle, the remote value is kept. A same-cycle clear and remote set of one bit leave that bit set.
- R14: Any error response carries zero read data, and every write response carries zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_i | input | 1 | Local bus request valid |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (16) | Byte address; low 9 bits used |
| bus_size_i | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| bus_wdata_i | input | 64 | Write data, byte 0 in bits 7:0 |
| rsp_vld_o | output | 1 | Response valid, one cycle after request |
| rsp_rdata_o | output | 64 | Response read data |
| rsp_err_o | output | 1 | Response error |
| rmt_set_vld_i | input | 1 | Remote pending-bit set request |
| rmt_set_vec_i | input | VEC_W (5) | Bit to set |
| rmt_wr_vld_i | input | 1 | Remote word write request |
| rmt_wr_off_i | input | OFF_W (9) | Remote write offset |
| rmt_wr_data_i | input | 32 | Remote write data |
| irq_o | output | 1 | Level interrupt to the core |
| misalign_o | output | 1 | Sticky misalignment flag |

## Verification
The bench sweeps every offset of the 9-bit window with every size, and every mailbox start with every size, against a byte model. This catches a design that treats a partial word past 0x03f as legal, that writes bytes past the buffer end, or that forgets to zero-extend. Vectors 0 to 31 are set and then cleared in several mask patterns. A design that asserts the interrupt on every set, or drops it while bits remain, shows up on the line at once. Local and remote writes are made to collide on mailbox bytes, on enable, and on one pending bit. This exposes a design that lets the local write win. Writes to pending and set are checked for both an error and an unchanged read-back.

// File: rtl/ipi_rf_pkg.sv
package ipi_rf_pkg;

    localparam int OFF_STATUS = 'h000;
    localparam int OFF_ENABLE = 'h004;
    localparam int OFF_SET    = 'h008;
    localparam int OFF_CLEAR  = 'h00c;

    typedef enum logic [2:0] {
        RGN_STATUS,
        RGN_ENABLE,
        RGN_SET,
        RGN_CLEAR,
        RGN_MBOX,
        RGN_NONE
    } region_e;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_RAISED
    } irq_st_e;

    function automatic logic [63:0] size_mask(input logic [1:0] sz);
        unique case (sz)
            2'd0:    size_mask = 64'h0000_0000_0000_00ff;
            2'd1:    size_mask = 64'h0000_0000_0000_ffff;
            2'd2:    size_mask = 64'h0000_0000_ffff_ffff;
            default: size_mask = 64'hffff_ffff_ffff_ffff;
        endcase
    endfunction

endpackage

// File: rtl/ipi_rf_decode.sv
module ipi_rf_decode
    import ipi_rf_pkg::*;
#(
    parameter int OFF_W      = 9,
    parameter int MBOX_BASE  = 32,
    parameter int MBOX_BYTES = 32,
    parameter int MB_AW      = $clog2(MBOX_BYTES)
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic [1:0]       size_i,
    output region_e          rgn_o,
    output logic             range_err_o,
    output logic             misalign_o,
    output logic [MB_AW-1:0] mb_off_o
);

    logic [31:0] off_w;
    logic [31:0] len_w;

    always_comb begin
        off_w       = 32'(off_i);
        len_w       = 32'd1 << size_i;
        misalign_o  = (off_w & (len_w - 32'd1)) != 32'd0;
        range_err_o = 1'b0;
        mb_off_o    = MB_AW'(off_w - 32'(MBOX_BASE));
        if (off_w == 32'(OFF_STATUS)) begin
            rgn_o = RGN_STATUS;
        end else if (off_w == 32'(OFF_ENABLE)) begin
            rgn_o = RGN_ENABLE;
        end else if (off_w == 32'(OFF_SET)) begin
            rgn_o = RGN_SET;
        end else if (off_w == 32'(OFF_CLEAR)) begin
            rgn_o = RGN_CLEAR;
        end else if (off_w >= 32'(MBOX_BASE) && off_w < 32'(MBOX_BASE + MBOX_BYTES)) begin
            rgn_o       = RGN_MBOX;
            range_err_o = (off_w - 32'(MBOX_BASE) + len_w) > 32'(MBOX_BYTES);
        end else begin
            rgn_o = RGN_NONE;
        end
    end

endmodule

// File: rtl/ipi_rf_mailbox.sv
module ipi_rf_mailbox #(
    parameter int BYTES  = 32,
    parameter int DATA_W = 64,
    parameter int WORD_W = 32,
    parameter int AW     = $clog2(BYTES),
    parameter int WAW    = AW - $clog2(WORD_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_we_i,
    input  logic [AW-1:0]     loc_off_i,
    input  logic [1:0]        loc_size_i,
    input  logic [DATA_W-1:0] loc_wdata_i,
    input  logic              rmt_we_i,
    input  logic [WAW-1:0]    rmt_word_i,
    input  logic [WORD_W-1:0] rmt_wdata_i,
    input  logic [AW-1:0]     rd_off_i,
    input  logic [1:0]        rd_size_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int LANES = DATA_W / 8;
    localparam int WB    = WORD_W / 8;
    localparam int LW    = $clog2(LANES);

    logic [8*BYTES-1:0] mem_q;
    logic [8*BYTES-1:0] mem_d;

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        logic [31:0]   rel;
        logic [LW+2:0] lane_base;
        logic          loc_hit;
        logic          rmt_hit;

        assign rel       = 32'(b) - 32'(loc_off_i);
        assign lane_base = {rel[LW-1:0], 3'b000};
        assign loc_hit   = loc_we_i && (32'(b) >= 32'(loc_off_i))
                           && (rel < (32'd1 << loc_size_i));
        assign rmt_hit   = rmt_we_i && (32'(rmt_word_i) == 32'(b / WB));
        // remote data wins over local data for the same byte
        assign mem_d[8*b +: 8] = rmt_hit ? rmt_wdata_i[8*(b % WB) +: 8]
                               : loc_hit ? loc_wdata_i[lane_base +: 8]
                               : mem_q[8*b +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < LANES; i++) begin
            if (32'(i) < (32'd1 << rd_size_i) && (32'(rd_off_i) + 32'(i)) < 32'(BYTES)) begin
                rd_data_o[8*i +: 8] = mem_q[8*(32'(rd_off_i) + 32'(i)) +: 8];
            end
        end
    end

    a_r8_no_write_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        loc_we_i |-> (32'(loc_off_i) + (32'd1 << loc_size_i)) <= 32'(BYTES));

endmodule

// File: rtl/ipi_rf_status.sv
module ipi_rf_status
    import ipi_rf_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int VEC_W  = $clog2(STAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_vld_i,
    input  logic [VEC_W-1:0]  set_vec_i,
    input  logic              clr_vld_i,
    input  logic [STAT_W-1:0] clr_mask_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);

    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] status_d;
    irq_st_e           state_q;
    irq_st_e           state_d;

    always_comb begin
        status_d = status_q;
        if (clr_vld_i) status_d = status_d & ~clr_mask_i;
        if (set_vld_i) status_d = status_d | (STAT_W'(1) << set_vec_i);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (status_d != '0) state_d = IRQ_RAISED;
            IRQ_RAISED: if (status_d == '0) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= IRQ_IDLE;
            status_q <= '0;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
        end
    end

    always_comb begin
        irq_o    = (state_q == IRQ_RAISED);
        status_o = status_q;
    end

    a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (status_q != '0));

    a_r6_rise_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(status_q) == '0);

    a_r3_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_vld_i && !clr_vld_i) |=> $stable(status_q));

    a_r13_set_survives_clear: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld_i |=> status_q[$past(set_vec_i)]);

endmodule

// File: rtl/ipi_core_regfile.sv
module ipi_core_regfile
    import ipi_rf_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int OFF_W      = 9,
    parameter int MBOX_BASE  = 32,
    parameter int MBOX_BYTES = 32,
    parameter int STAT_W     = 32,
    parameter int VEC_W      = $clog2(STAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [1:0]        bus_size_i,
    input  logic [63:0]       bus_wdata_i,
    output logic              rsp_vld_o,
    output logic [63:0]       rsp_rdata_o,
    output logic              rsp_err_o,
    input  logic              rmt_set_vld_i,
    input  logic [VEC_W-1:0]  rmt_set_vec_i,
    input  logic              rmt_wr_vld_i,
    input  logic [OFF_W-1:0]  rmt_wr_off_i,
    input  logic [31:0]       rmt_wr_data_i,
    output logic              irq_o,
    output logic              misalign_o
);

    localparam int MB_AW  = $clog2(MBOX_BYTES);
    localparam int MB_WAW = MB_AW - 2;

    logic [OFF_W-1:0]  off;
    region_e           rgn;
    logic              range_err;
    logic              misalign;
    logic [MB_AW-1:0]  mb_off;
    logic              acc_err;
    logic [63:0]       rd_raw;
    logic [63:0]       rd_val;
    logic [63:0]       mb_rd;
    logic [STAT_W-1:0] status;
    logic [31:0]       en_q;
    logic              loc_en_we;
    logic              loc_clr;
    logic              loc_mb_we;
    logic              rmt_mb_hit;
    logic              rmt_en_hit;
    logic [MB_WAW-1:0] rmt_word;
    logic              rsp_vld_q;
    logic              rsp_err_q;
    logic [63:0]       rsp_rdata_q;
    logic              mis_q;

    assign off = bus_addr_i[OFF_W-1:0];

    ipi_rf_decode #(
        .OFF_W     (OFF_W),
        .MBOX_BASE (MBOX_BASE),
        .MBOX_BYTES(MBOX_BYTES)
    ) decode_i (
        .off_i      (off),
        .size_i     (bus_size_i),
        .rgn_o      (rgn),
        .range_err_o(range_err),
        .misalign_o (misalign),
        .mb_off_o   (mb_off)
    );

    always_comb begin
        acc_err = 1'b0;
        rd_raw  = '0;
        unique case (rgn)
            RGN_STATUS: begin acc_err = bus_wr_i; rd_raw = 64'(status); end
            RGN_ENABLE: rd_raw  = 64'(en_q);
            RGN_SET:    acc_err = bus_wr_i;
            RGN_CLEAR:  rd_raw  = '0;
            RGN_MBOX:   begin acc_err = range_err; rd_raw = mb_rd; end
            default:    acc_err = 1'b1;
        endcase
        rd_val = (bus_wr_i || acc_err) ? 64'd0 : (rd_raw & size_mask(bus_size_i));
    end

    assign loc_en_we  = bus_req_i && bus_wr_i && (rgn == RGN_ENABLE);
    assign loc_clr    = bus_req_i && bus_wr_i && (rgn == RGN_CLEAR);
    assign loc_mb_we  = bus_req_i && bus_wr_i && (rgn == RGN_MBOX) && !range_err;
    assign rmt_mb_hit = rmt_wr_vld_i && (32'(rmt_wr_off_i) >= 32'(MBOX_BASE))
                        && (32'(rmt_wr_off_i) < 32'(MBOX_BASE + MBOX_BYTES));
    assign rmt_en_hit = rmt_wr_vld_i && ((32'(rmt_wr_off_i) >> 2) == 32'(OFF_ENABLE >> 2));
    assign rmt_word   = MB_WAW'((32'(rmt_wr_off_i) - 32'(MBOX_BASE)) >> 2);

    ipi_rf_mailbox #(
        .BYTES (MBOX_BYTES),
        .DATA_W(64),
        .WORD_W(32)
    ) mbox_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .loc_we_i   (loc_mb_we),
        .loc_off_i  (mb_off),
        .loc_size_i (bus_size_i),
        .loc_wdata_i(bus_wdata_i),
        .rmt_we_i   (rmt_mb_hit),
        .rmt_word_i (rmt_word),
        .rmt_wdata_i(rmt_wr_data_i),
        .rd_off_i   (mb_off),
        .rd_size_i  (bus_size_i),
        .rd_data_o  (mb_rd)
    );

    ipi_rf_status #(
        .STAT_W(STAT_W),
        .VEC_W (VEC_W)
    ) status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vld_i (rmt_set_vld_i),
        .set_vec_i (rmt_set_vec_i),
        .clr_vld_i (loc_clr),
        .clr_mask_i(bus_wdata_i[STAT_W-1:0]),
        .status_o  (status),
        .irq_o     (irq_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q        <= '0;
            mis_q       <= 1'b0;
            rsp_vld_q   <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            if (rmt_en_hit) begin
                en_q <= rmt_wr_data_i;
            end else if (loc_en_we) begin
                en_q <= bus_wdata_i[31:0];
            end
            if (bus_req_i && misalign) mis_q <= 1'b1;
            rsp_vld_q   <= bus_req_i;
            rsp_err_q   <= bus_req_i && acc_err;
            rsp_rdata_q <= bus_req_i ? rd_val : 64'd0;
        end
    end

    assign rsp_vld_o   = rsp_vld_q;
    assign rsp_err_o   = rsp_err_q;
    assign rsp_rdata_o = rsp_rdata_q;
    assign misalign_o  = mis_q;

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_i |=> rsp_vld_o);

    a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req_i |=> !rsp_vld_o);

    a_r14_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_o |-> rsp_rdata_o == 64'd0);

    a_r11_misalign_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |=> misalign_o);

    a_r8_range_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i && rgn == RGN_MBOX && range_err) |=> rsp_err_o);

    a_r10_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_en_we || rmt_en_hit) |=> $stable(en_q));

endmodule

// File: tb/ipi_core_regfile_tb_top.sv
module ipi_core_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [15:0] bus_addr_i = '0;
    logic [1:0]  bus_size_i = '0;
    logic [63:0] bus_wdata_i = '0;
    logic        rsp_vld_o;
    logic [63:0] rsp_rdata_o;
    logic        rsp_err_o;
    logic        rmt_set_vld_i = 1'b0;
    logic [4:0]  rmt_set_vec_i = '0;
    logic        rmt_wr_vld_i = 1'b0;
    logic [8:0]  rmt_wr_off_i = '0;
    logic [31:0] rmt_wr_data_i = '0;
    logic        irq_o;
    logic        misalign_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  mb [32];
    logic [31:0] st;
    logic [31:0] en;
    bit          mis;

    always #5 clk = ~clk;

    ipi_core_regfile dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_req_i(bus_req_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
        .bus_size_i(bus_size_i), .bus_wdata_i(bus_wdata_i),
        .rsp_vld_o(rsp_vld_o), .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o),
        .rmt_set_vld_i(rmt_set_vld_i), .rmt_set_vec_i(rmt_set_vec_i),
        .rmt_wr_vld_i(rmt_wr_vld_i), .rmt_wr_off_i(rmt_wr_off_i),
        .rmt_wr_data_i(rmt_wr_data_i),
        .irq_o(irq_o), .misalign_o(misalign_o)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic lreq, input logic lwr, input logic [15:0] addr,
                        input logic [1:0] sz, input logic [63:0] wd,
                        input logic sset, input logic [4:0] vec,
                        input logic rwr, input logic [8:0] roff, input logic [31:0] rwd,
                        input string tag);
        int o;
        int l;
        logic eerr;
        logic [63:0] raw;
        logic [63:0] erd;
        o = int'(addr[8:0]);
        l = 1 << sz;
        eerr = 1'b0;
        raw = '0;
        if (o == 0) begin eerr = lwr; raw = 64'(st); end
        else if (o == 4) raw = 64'(en);
        else if (o == 8) eerr = lwr;
        else if (o == 12) raw = '0;
        else if (o >= 32 && o < 64) begin
            eerr = (o + l) > 64;
            for (int i = 0; i < 8; i++)
                if (o - 32 + i < 32) raw[8*i +: 8] = mb[o - 32 + i];
        end else eerr = 1'b1;
        for (int i = l; i < 8; i++) raw[8*i +: 8] = 8'h00;
        erd = (lwr || eerr) ? 64'd0 : raw;

        @(negedge clk);
        bus_req_i = lreq; bus_wr_i = lwr; bus_addr_i = addr; bus_size_i = sz; bus_wdata_i = wd;
        rmt_set_vld_i = sset; rmt_set_vec_i = vec;
        rmt_wr_vld_i = rwr; rmt_wr_off_i = roff; rmt_wr_data_i = rwd;
        @(negedge clk);
        bus_req_i = 1'b0; rmt_set_vld_i = 1'b0; rmt_wr_vld_i = 1'b0;

        if (lreq) begin
            if ((o % l) != 0) mis = 1'b1;
            if (lwr && !eerr) begin
                if (o == 4) en = wd[31:0];
                else if (o == 12) st = st & ~wd[31:0];
                else if (o >= 32 && o < 64)
                    for (int i = 0; i < l; i++) mb[o - 32 + i] = wd[8*i +: 8];
            end
        end
        if (sset) st = st | (32'd1 << vec);
        if (rwr) begin
            if (roff >= 9'd32 && roff < 9'd64)
                for (int i = 0; i < 4; i++) mb[((int'(roff) - 32) & ~3) + i] = rwd[8*i +: 8];
            else if ((roff >> 2) == 9'd1) en = rwd;
        end

        if (lreq) begin
            chk(tag, "rsp_vld", 64'(rsp_vld_o), 64'd1);
            chk(tag, "rsp_err", 64'(rsp_err_o), 64'(eerr));
            chk(tag, "rsp_rdata", rsp_rdata_o, erd);
        end else begin
            chk(tag, "rsp_vld idle", 64'(rsp_vld_o), 64'd0);
        end
        chk(tag, "irq", 64'(irq_o), 64'(st != 0));
        chk(tag, "misalign", 64'(misalign_o), 64'(mis));
    endtask

    task automatic rd(input logic [15:0] a, input logic [1:0] s, input string tag);
        step(1, 0, a, s, '0, 0, '0, 0, '0, '0, tag);
    endtask
    task automatic wr(input logic [15:0] a, input logic [1:0] s, input logic [63:0] d, input string tag);
        step(1, 1, a, s, d, 0, '0, 0, '0, '0, tag);
    endtask
    task automatic rset(input logic [4:0] v, input string tag);
        step(0, 0, '0, 2'd0, '0, 1, v, 0, '0, '0, tag);
    endtask
    task automatic rwrite(input logic [8:0] ro, input logic [31:0] d, input string tag);
        step(0, 0, '0, 2'd0, '0, 0, '0, 1, ro, d, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) mb[i] = 8'h00;
        st = '0; en = '0; mis = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2", "reset rsp_vld", 64'(rsp_vld_o), 64'd0);
        chk("R2", "reset irq", 64'(irq_o), 64'd0);
        chk("R2", "reset misalign", 64'(misalign_o), 64'd0);
        rst_n = 1'b1;

        // R2/R4: aligned reads of reset state
        rd(16'h0000, 2'd2, "R2");
        rd(16'h0008, 2'd2, "R4");
        rd(16'h000c, 2'd2, "R4");

        // R1: high address bits ignored; R10: enable store and masked read
        wr(16'h7004, 2'd2, 64'hdead_beef_a5c3_9612, "R1");
        rd(16'h0004, 2'd2, "R10");
        rd(16'hf004, 2'd0, "R1");
        rd(16'h0004, 2'd1, "R10");
        wr(16'h0004, 2'd0, 64'h0000_0000_1234_5678, "R10");
        rd(16'h0004, 2'd2, "R10");

        // R11: first misaligned access sets the flag, which then sticks
        chk("R11", "flag still clear", 64'(misalign_o), 64'd0);
        rd(16'h0022, 2'd2, "R11");
        rd(16'h0020, 2'd3, "R11");

        // R7/R8: every mailbox start with every size, write then read
        for (int o = 32; o < 64; o++) begin
            for (int s = 0; s < 4; s++) begin
                logic [63:0] pat;
                pat = {8{8'(o * 7 + s * 29)}} ^ 64'h0123_4567_89ab_cdef;
                wr(16'(o), 2'(s), pat, (o + (1 << s) > 64) ? "R8" : "R7");
                rd(16'(o), 2'(s), (o + (1 << s) > 64) ? "R8" : "R7");
            end
        end
        for (int o = 32; o < 64; o += 8) rd(16'(o), 2'd3, "R7");

        // R9/R14: read sweep of the whole window, every size
        for (int o = 0; o < 512; o++)
            for (int s = 0; s < 4; s++) rd(16'(o), 2'(s), "R9");
        wr(16'h0050, 2'd2, 64'hffff_ffff_ffff_ffff, "R9");
        wr(16'h0010, 2'd2, 64'hffff_ffff_ffff_ffff, "R9");
        rd(16'h0004, 2'd2, "R9");

        // R6: remote sets of every vector; line rises only on the first
        for (int v = 0; v < 32; v++) begin
            rset(5'(v), "R6");
            rd(16'h0000, 2'd2, "R6");
        end
        // R3: writes to pending and set are refused and change nothing
        wr(16'h0000, 2'd2, 64'h0, "R3");
        wr(16'h0008, 2'd2, 64'hffff_ffff, "R3");
        rd(16'h0000, 2'd2, "R3");
        // R5: clear in several masks; line drops only at zero
        wr(16'h000c, 2'd2, 64'h0000_0000_5555_5555, "R5");
        rd(16'h0000, 2'd2, "R5");
        wr(16'h000c, 2'd0, 64'h0000_0000_0000_00ff, "R5");
        rd(16'h0000, 2'd2, "R5");
        wr(16'h000c, 2'd2, 64'h0000_0000_aaaa_0000, "R5");
        rd(16'h0000, 2'd1, "R5");
        wr(16'h000c, 2'd2, 64'h0000_0000_ffff_ffff, "R5");
        rset(5'd31, "R6");
        rset(5'd3, "R6");
        wr(16'h000c, 2'd2, 64'h0000_0000_8000_0000, "R5");
        wr(16'h000c, 2'd2, 64'h0000_0000_0000_0008, "R5");

        // R12: remote word writes to mailbox, enable, and ignored offsets
        for (int w = 0; w < 8; w++) begin
            rwrite(9'(32 + 4 * w + (w % 4)), 32'h1000_0001 * (w + 3), "R12");
            rd(16'(32 + 4 * w), 2'd2, "R12");
        end
        rwrite(9'h004, 32'h0bad_f00d, "R12");
        rd(16'h0004, 2'd2, "R12");
        rwrite(9'h000, 32'hffff_ffff, "R12");
        rwrite(9'h00c, 32'hffff_ffff, "R12");
        rwrite(9'h100, 32'hffff_ffff, "R12");
        rd(16'h0000, 2'd2, "R12");
        rd(16'h0004, 2'd2, "R12");

        // R13: same-cycle collisions
        step(1, 1, 16'h0020, 2'd3, 64'h1111_2222_3333_4444, 0, '0, 1, 9'h024, 32'hcafe_babe, "R13");
        rd(16'h0020, 2'd3, "R13");
        step(1, 1, 16'h0004, 2'd2, 64'h7777_7777, 0, '0, 1, 9'h004, 32'h0000_0042, "R13");
        rd(16'h0004, 2'd2, "R13");
        step(1, 1, 16'h000c, 2'd2, 64'hffff_ffff, 1, 5'd9, 0, '0, '0, "R13");
        rd(16'h0000, 2'd2, "R13");
        wr(16'h000c, 2'd2, 64'hffff_ffff, "R5");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule